// File: doc/BRIEF.md
# Reset-hold duration counter

This block measures how long an active-low system reset pin is held low, so that software can tell a long press from a short one. A long press can then trigger a return to factory settings. The block runs on a reference clock of 25 MHz by default. The pin passes through a two-flop synchronizer. While the synchronized pin is low, a 29-bit counter advances by one on every reference cycle.

When the counter reaches all ones it stops and stays there. It also keeps its value after the pin goes high again. Only a write with bit 31 set clears it, or the block's own register reset, which is separate from the monitored pin. A second low period that starts before any clear adds onto the count already held.

Software sets a threshold in whole seconds. The `long_press` output is high when that threshold is nonzero and the count has reached the threshold times the number of reference cycles in one second.

Top module: `rst_hold_meter`

## Requirements
- R1: After `rst_n` is released, the count, the threshold and `long_press` are all zero.
- R2: A low period of the monitored pin that covers N clock edges adds exactly N to the count. The pin is seen through two flops, so each increment lands two edges after the edge that sampled the pin low.
- R3: The count stops at its all-ones value (2^CNT_W-1) and never wraps to zero.
- R4: While the synchronized pin is high and no clear is written, the count holds its value.
- R5: A write to address 0 with `wr_data[31]`=1 clears the count at that edge. The clear takes priority over an increment at the same edge. A write to address 0 with `wr_data[31]`=0 leaves the count unchanged.
- R6: A new low period that starts without a clear in between adds onto the existing count.
- R7: `rd_data` is combinational. Address 0 returns the count in bits [CNT_W-1:0], with every higher bit zero. Address 1 returns the threshold in bits [SEC_W-1:0], with the higher bits zero.
- R8: A write to address 1 loads `wr_data[SEC_W-1:0]` as the threshold. `long_press` = (threshold != 0) && (count >= threshold * TICKS_PER_SEC), evaluated combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset of the block's own registers |
| pin_n | input | 1 | Monitored active-low reset pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 selects the count, 1 selects the threshold |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 selects the count, 1 selects the threshold |
| rd_data | output | 32 | Read data |
| long_press | output | 1 | High when the count has reached the threshold in seconds |

## Verification
The bench builds the block with CNT_W=6, TICKS_PER_SEC=10 and SEC_W=4. At these values, saturation at 63 counts is reached within a few dozen cycles. One "second" is 10 cycles, so a threshold of 3 seconds can be tested exactly at 29, 30 and 35 counts. The small widths also make it quick to check that the read word carries zeros above the count field. The clear-versus-increment race is checked by clearing while the pin is still low and then counting the increments that were already in the synchronizer.

// File: rtl/rst_hold_meter.sv
module rst_hold_meter #(
  parameter int CNT_W         = 29,
  parameter int TICKS_PER_SEC = 25_000_000,
  parameter int SEC_W         = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_addr,
  output logic [31:0] rd_data,
  output logic        long_press
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEC_W-1:0] thr_q;
  logic             clr, thr_we, held_low;
  logic [63:0]      target;
  logic             unused_wr;

  assign clr      = wr_en && !wr_addr && wr_data[31];
  assign thr_we   = wr_en && wr_addr;
  assign held_low = !sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], pin_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clr)                      cnt_q <= '0;
    else if (held_low && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_we) thr_q <= wr_data[SEC_W-1:0];
  end

  assign target     = 64'(thr_q) * 64'(TICKS_PER_SEC);
  assign long_press = (thr_q != '0) && (64'(cnt_q) >= target);
  assign rd_data    = rd_addr ? 32'(thr_q) : 32'(cnt_q);
  assign unused_wr  = ^wr_data;
endmodule

module rst_hold_meter_chk #(
  parameter int CNT_W = 29,
  parameter int SEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       sync_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [SEC_W-1:0] thr_q,
  input logic             clr,
  input logic             rd_addr,
  input logic [31:0]      rd_data,
  input logic             long_press
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q[1] && !clr) |=> $stable(cnt_q));
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  // R8
  thr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == '0) |-> !long_press);
  // R7
  rd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_addr |-> rd_data[31:CNT_W] == '0);
endmodule

bind rst_hold_meter rst_hold_meter_chk #(.CNT_W(CNT_W), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .cnt_q(cnt_q), .thr_q(thr_q),
  .clr(clr), .rd_addr(rd_addr), .rd_data(rd_data), .long_press(long_press)
);

// File: tb/sim_rst_hold_meter.sv
module sim_rst_hold_meter;
  localparam int CW = 6, TPS = 10, SW = 4;

  logic clk = 0, rst_n = 0, pin_n = 1, wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic long_press;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rst_hold_meter #(.CNT_W(CW), .TICKS_PER_SEC(TPS), .SEC_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .long_press(long_press)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic press(int n);
    @(negedge clk); pin_n = 0;
    repeat (n) @(negedge clk);
    pin_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); check("R1 count", v, 0);
    rd(1, v); check("R1 thr", v, 0);
    check("R1 long_press", 32'(long_press), 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    press(20); rd(0, v); check("R2 count after 20", v, 20);
    repeat (5) @(negedge clk); rd(0, v); check("R4 held after release", v, 20);
  endtask

  task automatic t_accum();
    logic [31:0] v;
    press(15); rd(0, v); check("R6 accumulate", v, 35);
  endtask

  task automatic t_thresh();
    logic [31:0] v;
    wr(1, 32'hFFFF_FFF3); rd(1, v); check("R7 thr read", v, 3);
    check("R8 35>=30", 32'(long_press), 1);
    wr(1, 4); check("R8 35<40", 32'(long_press), 0);
    wr(1, 0); check("R8 thr zero", 32'(long_press), 0);
    wr(0, 32'h8000_0000); wr(1, 3);
    press(29); check("R8 29<30", 32'(long_press), 0);
    press(1);  check("R8 30>=30", 32'(long_press), 1);
  endtask

  task automatic t_saturate();
    logic [31:0] v;
    press(50); rd(0, v); check("R3 saturate", v, 63);
    press(5); rd(0, v); check("R3 no wrap", v, 63);
    check("R7 upper bits zero", {26'd0, v[5:0]} == v ? 32'd1 : 32'd0, 1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(0, 32'h7FFF_FFFF); rd(0, v); check("R5 no clear without bit31", v, 63);
    wr(0, 32'h8000_0000); rd(0, v); check("R5 clear", v, 0);
    @(negedge clk); pin_n = 0;
    repeat (6) @(negedge clk);
    wr_en = 1; wr_addr = 0; wr_data = 32'h8000_0000;
    @(negedge clk); wr_en = 0; wr_data = '0;
    rd(0, v); check("R5 clear wins over increment", v, 0);
    pin_n = 1;
    repeat (4) @(negedge clk);
    rd(0, v); check("R5 pipeline after clear", v, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_accum();
    t_thresh();
    t_saturate();
    t_clear();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule